// File: doc/BRIEF.md
# Sensor Scratchpad with Alarm Compare

This block is the register file behind the memory command layer of a digital temperature sensor. It holds a 16-bit sign-extended temperature result in half-degree units, working copies of an upper and a lower trigger byte, two count bytes from the converter and two filler bytes. A command engine reads any byte by its index. Index 8 returns a CRC-8 over the eight data bytes, and this CRC is always current. The same engine can replace both trigger bytes in a single write beat.

The converter presents each finished result on a one-cycle load strobe. One cycle after the load, the block compares the integer part of the new temperature against both triggers as signed values and updates the alarm output. The alarm output is a plain level that the search logic can sample. Trigger writes use a valid/ready pair. They stall only in a cycle where a result is being loaded.

Byte reads use a request channel and a response channel. A request is taken when `rd_valid` and `rd_ready` are both high. Its byte appears on the response channel one cycle later. `rd_ready` is low only while a response waits and `rdo_ready` is low. A stalled response holds its data unchanged until it is taken.

Top module: `spad_top`

## Requirements
- R1: After reset, bytes 0 and 1 read AAh and 00h (+85 degrees), bytes 2, 3, 6 and 7 read their reset parameters (defaults 4Bh, 46h, 0Ch, 10h), and `alarm` is 0.
- R2: A cycle with `ld_strobe` high writes the temperature into bytes 0 (low) and 1 (high), and the two count inputs into bytes 6 and 7, all at the same clock edge.
- R3: An accepted trigger write (`tw_valid` and `tw_ready`) places `tw_high` in byte 2 and `tw_low` in byte 3. `tw_ready` is low in any cycle where `ld_strobe` is high.
- R4: Bytes 4 and 5 always read FFh. Indices 9 to 15 also read FFh.
- R5: Byte 8 is the CRC of bytes 0 to 7, taken in index order. The CRC uses polynomial x^8+x^5+x^4+1, starts from zero and takes each byte least significant bit first. It reflects the current register contents on every read. Passing bytes 0 to 8 through the same generator leaves zero.
- R6: The alarm is set when temperature bits 15:1 (the half-degree bit dropped, signed) are greater than the signed upper trigger, or less than the signed lower trigger. Otherwise the alarm is cleared.
- R7: `alarm` changes only at the clock edge one cycle after a load. It still shows the previous outcome in the cycle right after the load. A trigger write alone never changes it.
- R8: A read request taken at one edge gives `rdo_valid` high with the requested byte after that edge. `rd_ready` equals `!rdo_valid || rdo_ready`. While `rdo_valid` is high and `rdo_ready` is low, `rdo_data` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_strobe | input | 1 | Load a conversion result this cycle |
| ld_temp | input | 16 | Sign-extended temperature, 0.5 degree per LSB |
| ld_cnt_remain | input | 8 | Count byte stored at index 6 |
| ld_cnt_per | input | 8 | Count byte stored at index 7 |
| tw_valid | input | 1 | Trigger write request |
| tw_ready | output | 1 | Trigger write can be accepted |
| tw_high | input | 8 | New upper trigger (signed degrees) |
| tw_low | input | 8 | New lower trigger (signed degrees) |
| rd_valid | input | 1 | Byte read request |
| rd_ready | output | 1 | Read request can be accepted |
| rd_index | input | 4 | Byte index to read |
| rdo_valid | output | 1 | Read response valid |
| rdo_ready | input | 1 | Consumer takes the response |
| rdo_data | output | 8 | Response byte |
| alarm | output | 1 | Temperature outside trigger window |

## Verification
A wrong stored byte shows up on the next read of its index. It also corrupts the byte-8 CRC, so one read of index 8 exposes damage to any of the eight registers within two cycles. A wrong compare or a wrong evaluation cycle shows on `alarm` at the second sampling point after a load. The checks probe signed limits exactly at each trigger and half a degree on either side. A stalled response whose data drifts is visible during the stall, before any new request can be taken.

// File: rtl/spad_pkg.sv
package spad_pkg;
  localparam int BYTE_W     = 8;
  localparam int DATA_BYTES = 8;
  localparam int IDX_W      = 4;
  localparam int TEMP_W     = 2 * BYTE_W;
  localparam int IMG_W      = BYTE_W * DATA_BYTES;
  localparam int CMP_W      = TEMP_W - 1;

  localparam logic [BYTE_W-1:0] CRC_POLY_LSBF = 8'h8C;
  localparam logic [BYTE_W-1:0] FILL_BYTE     = 8'hFF;

  typedef enum logic [IDX_W-1:0] {
    IX_TEMP_LO = 4'd0,
    IX_TEMP_HI = 4'd1,
    IX_TRIG_HI = 4'd2,
    IX_TRIG_LO = 4'd3,
    IX_FILL_A  = 4'd4,
    IX_FILL_B  = 4'd5,
    IX_CNT_REM = 4'd6,
    IX_CNT_PER = 4'd7,
    IX_CHECK   = 4'd8
  } spad_idx_e;

  // Advance a reflected CRC-8 by one byte, least significant bit first.
  function automatic logic [BYTE_W-1:0] crc_step_byte(input logic [BYTE_W-1:0] crc_in,
                                                      input logic [BYTE_W-1:0] din);
    logic [BYTE_W-1:0] c;
    logic              fb;
    c = crc_in;
    for (int b = 0; b < BYTE_W; b++) begin
      fb = c[0] ^ din[b];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_LSBF;
    end
    return c;
  endfunction
endpackage

// File: rtl/spad_regs.sv
module spad_regs
  import spad_pkg::*;
#(
  parameter logic [TEMP_W-1:0] TEMP_RST = 16'h00AA,
  parameter logic [BYTE_W-1:0] TH_RST   = 8'h4B,
  parameter logic [BYTE_W-1:0] TL_RST   = 8'h46,
  parameter logic [BYTE_W-1:0] CR_RST   = 8'h0C,
  parameter logic [BYTE_W-1:0] CP_RST   = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [TEMP_W-1:0] ld_temp,
  input  logic [BYTE_W-1:0] ld_cnt_rem,
  input  logic [BYTE_W-1:0] ld_cnt_per,
  input  logic              tw_en,
  input  logic [BYTE_W-1:0] tw_th,
  input  logic [BYTE_W-1:0] tw_tl,
  output logic [TEMP_W-1:0] temp_q,
  output logic [BYTE_W-1:0] th_q,
  output logic [BYTE_W-1:0] tl_q,
  output logic [IMG_W-1:0]  image
);
  logic [BYTE_W-1:0] cnt_rem_q, cnt_per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q    <= TEMP_RST;
      cnt_rem_q <= CR_RST;
      cnt_per_q <= CP_RST;
    end else if (ld_en) begin
      temp_q    <= ld_temp;
      cnt_rem_q <= ld_cnt_rem;
      cnt_per_q <= ld_cnt_per;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      th_q <= TH_RST;
      tl_q <= TL_RST;
    end else if (tw_en) begin
      th_q <= tw_th;
      tl_q <= tw_tl;
    end
  end

  // Byte k of the image sits at bits [k*8 +: 8].
  assign image = {cnt_per_q, cnt_rem_q, FILL_BYTE, FILL_BYTE,
                  tl_q, th_q, temp_q[TEMP_W-1:BYTE_W], temp_q[BYTE_W-1:0]};
endmodule

// File: rtl/spad_crc.sv
module spad_crc
  import spad_pkg::*;
(
  input  logic [IMG_W-1:0]  image,
  output logic [BYTE_W-1:0] crc
);
  logic [BYTE_W-1:0] chain [DATA_BYTES+1];

  assign chain[0] = '0;

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_stage
    assign chain[g+1] = crc_step_byte(chain[g], image[g*BYTE_W +: BYTE_W]);
  end

  assign crc = chain[DATA_BYTES];
endmodule

// File: rtl/spad_alarm.sv
module spad_alarm
  import spad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_req,
  input  logic [TEMP_W-1:0] temp,
  input  logic [BYTE_W-1:0] th,
  input  logic [BYTE_W-1:0] tl,
  output logic              alarm
);
  localparam int EXT_W = CMP_W - BYTE_W;

  logic              pend_q;
  logic signed [CMP_W-1:0] whole, hi_lim, lo_lim;
  logic              hot, cold;

  assign whole  = signed'(temp[TEMP_W-1:1]);
  assign hi_lim = signed'({{EXT_W{th[BYTE_W-1]}}, th});
  assign lo_lim = signed'({{EXT_W{tl[BYTE_W-1]}}, tl});
  assign hot    = whole > hi_lim;
  assign cold   = whole < lo_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      alarm  <= 1'b0;
    end else begin
      pend_q <= eval_req;
      if (pend_q) alarm <= hot | cold;
    end
  end
endmodule

// File: rtl/spad_top.sv
module spad_top
  import spad_pkg::*;
#(
  parameter logic [15:0] TEMP_RST = 16'h00AA,
  parameter logic [7:0]  TH_RST   = 8'h4B,
  parameter logic [7:0]  TL_RST   = 8'h46,
  parameter logic [7:0]  CR_RST   = 8'h0C,
  parameter logic [7:0]  CP_RST   = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_strobe,
  input  logic [15:0] ld_temp,
  input  logic [7:0]  ld_cnt_remain,
  input  logic [7:0]  ld_cnt_per,
  input  logic        tw_valid,
  output logic        tw_ready,
  input  logic [7:0]  tw_high,
  input  logic [7:0]  tw_low,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic [3:0]  rd_index,
  output logic        rdo_valid,
  input  logic        rdo_ready,
  output logic [7:0]  rdo_data,
  output logic        alarm
);
  logic [TEMP_W-1:0] temp_q;
  logic [BYTE_W-1:0] th_q, tl_q, crc, sel_byte, rdo_data_q;
  logic [IMG_W-1:0]  image;
  logic              tw_fire, rd_fire, rdo_valid_q;

  assign tw_ready = ~ld_strobe;
  assign tw_fire  = tw_valid & tw_ready;

  spad_regs #(
    .TEMP_RST(TEMP_RST), .TH_RST(TH_RST), .TL_RST(TL_RST),
    .CR_RST(CR_RST), .CP_RST(CP_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_strobe), .ld_temp(ld_temp),
    .ld_cnt_rem(ld_cnt_remain), .ld_cnt_per(ld_cnt_per),
    .tw_en(tw_fire), .tw_th(tw_high), .tw_tl(tw_low),
    .temp_q(temp_q), .th_q(th_q), .tl_q(tl_q), .image(image)
  );

  spad_crc u_crc (.image(image), .crc(crc));

  spad_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .eval_req(ld_strobe),
    .temp(temp_q), .th(th_q), .tl(tl_q), .alarm(alarm)
  );

  always_comb begin
    if (rd_index < IX_CHECK)      sel_byte = image[rd_index[2:0]*BYTE_W +: BYTE_W];
    else if (rd_index == IX_CHECK) sel_byte = crc;
    else                           sel_byte = FILL_BYTE;
  end

  assign rd_ready = ~rdo_valid_q | rdo_ready;
  assign rd_fire  = rd_valid & rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdo_valid_q <= 1'b0;
      rdo_data_q  <= '0;
    end else if (rd_fire) begin
      rdo_valid_q <= 1'b1;
      rdo_data_q  <= sel_byte;
    end else if (rdo_ready) begin
      rdo_valid_q <= 1'b0;
    end
  end

  assign rdo_valid = rdo_valid_q;
  assign rdo_data  = rdo_data_q;
endmodule

// File: rtl/spad_chk.sv
module spad_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_strobe,
  input logic       tw_valid,
  input logic       tw_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [3:0] rd_index,
  input logic       rdo_valid,
  input logic       rdo_ready,
  input logic [7:0] rdo_data,
  input logic       alarm
);
  // R8
  rd_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdo_valid && !rdo_ready |=> rdo_valid && $stable(rdo_data));
  // R8
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> rdo_valid);
  // R8
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdo_valid && !rdo_ready |-> !rd_ready);
  // R4
  fill_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && (rd_index == 4'd4 || rd_index == 4'd5 || rd_index > 4'd8)
    |=> rdo_data == 8'hFF);
  // R7
  alarm_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarm) |-> $past(ld_strobe, 2));
  // R3
  tw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid && ld_strobe |-> !tw_ready);
endmodule

bind spad_top spad_chk u_chk (.*);

// File: tb/tb_spad_top.sv
`timescale 1ns/1ps
module tb_spad_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_strobe = 1'b0;
  logic [15:0] ld_temp = '0;
  logic [7:0]  ld_cnt_remain = '0, ld_cnt_per = '0;
  logic        tw_valid = 1'b0;
  logic        tw_ready;
  logic [7:0]  tw_high = '0, tw_low = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [3:0]  rd_index = '0;
  logic        rdo_valid;
  logic        rdo_ready = 1'b1;
  logic [7:0]  rdo_data;
  logic        alarm;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spad_top dut (.*);

  // {temp, count_remain, count_per, upper, lower, expected alarm}
  localparam logic [55:0] VEC [8] = '{
    {16'h0032, 8'h0C, 8'h10, 8'h4B, 8'h0A, 8'h00},
    {16'h00FA, 8'h01, 8'h10, 8'h4B, 8'h0A, 8'h01},
    {16'hFF92, 8'h05, 8'h10, 8'h4B, 8'hF6, 8'h01},
    {16'h0097, 8'h0A, 8'h10, 8'h4B, 8'hF6, 8'h00},
    {16'h0098, 8'h03, 8'h10, 8'h4B, 8'hF6, 8'h01},
    {16'hFFEC, 8'h07, 8'h10, 8'h4B, 8'hF6, 8'h00},
    {16'hFFEB, 8'h0F, 8'h10, 8'h4B, 8'hF6, 8'h01},
    {16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  function automatic logic [7:0] ref_crc(input logic [7:0] bytes [9], input int n);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic mix = r[0] ^ bytes[i][b];
        r = {1'b0, r[7:1]} ^ (mix ? 8'h8C : 8'h00);
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic read_byte(input logic [3:0] idx, output logic [7:0] val);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_index = idx;
    rdo_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    val = rdo_data;
    check(rdo_valid === 1'b1, "R8", "response valid", {15'd0, rdo_valid}, 16'd1);
  endtask

  task automatic load(input logic [15:0] t, input logic [7:0] cr, input logic [7:0] cp);
    @(negedge clk);
    ld_strobe = 1'b1; ld_temp = t; ld_cnt_remain = cr; ld_cnt_per = cp;
    @(negedge clk);
    ld_strobe = 1'b0;
  endtask

  task automatic trig_write(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    tw_valid = 1'b1; tw_high = hi; tw_low = lo;
    @(negedge clk);
    tw_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic [7:0] exp_b [9];
    logic       prev_alarm;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    check(alarm === 1'b0, "R1", "reset alarm", {15'd0, alarm}, 16'd0);
    exp_b = '{8'hAA, 8'h00, 8'h4B, 8'h46, 8'hFF, 8'hFF, 8'h0C, 8'h10, 8'h00};
    exp_b[8] = ref_crc(exp_b, 8);
    for (int i = 0; i < 9; i++) begin
      read_byte(4'(i), got);
      check(got === exp_b[i], (i == 8) ? "R5" : "R1", $sformatf("reset byte %0d", i),
            {8'd0, got}, {8'd0, exp_b[i]});
    end

    // Vector table: R2 R3 R4 R5 R6 R7
    prev_alarm = 1'b0;
    for (int v = 0; v < 8; v++) begin
      logic [55:0] e = VEC[v];
      trig_write(e[23:16], e[15:8]);
      check(alarm === prev_alarm, "R7", $sformatf("vec %0d alarm after trig write", v),
            {15'd0, alarm}, {15'd0, prev_alarm});
      load(e[55:40], e[39:32], e[31:24]);
      check(alarm === prev_alarm, "R7", $sformatf("vec %0d alarm one cycle after load", v),
            {15'd0, alarm}, {15'd0, prev_alarm});
      @(negedge clk);
      check(alarm === e[0], "R6", $sformatf("vec %0d alarm", v),
            {15'd0, alarm}, {15'd0, e[0]});
      prev_alarm = e[0];
      exp_b = '{e[47:40], e[55:48], e[23:16], e[15:8], 8'hFF, 8'hFF, e[39:32], e[31:24], 8'h00};
      exp_b[8] = ref_crc(exp_b, 8);
      for (int i = 0; i < 9; i++) begin
        read_byte(4'(i), got);
        check(got === exp_b[i],
              (i == 8) ? "R5" : (i == 2 || i == 3) ? "R3" : (i == 4 || i == 5) ? "R4" : "R2",
              $sformatf("vec %0d byte %0d", v, i), {8'd0, got}, {8'd0, exp_b[i]});
      end
      exp_b[8] = got;
      check(ref_crc(exp_b, 9) === 8'h00, "R5", $sformatf("vec %0d residue", v),
            {8'd0, ref_crc(exp_b, 9)}, 16'd0);
    end

    // R4: indices beyond the CRC
    for (int i = 9; i < 16; i++) begin
      read_byte(4'(i), got);
      check(got === 8'hFF, "R4", $sformatf("index %0d", i), {8'd0, got}, 16'h00FF);
    end

    // R7: trigger change without a new load leaves the alarm alone
    trig_write(8'h4B, 8'h0A);
    load(16'h00FA, 8'h00, 8'h10);
    @(negedge clk);
    check(alarm === 1'b1, "R6", "hot at 125", {15'd0, alarm}, 16'd1);
    trig_write(8'h7F, 8'h0A);
    repeat (3) @(negedge clk);
    check(alarm === 1'b1, "R7", "alarm held after trig write", {15'd0, alarm}, 16'd1);
    load(16'h00FA, 8'h00, 8'h10);
    @(negedge clk);
    check(alarm === 1'b0, "R6", "cleared after reload", {15'd0, alarm}, 16'd0);

    // R3: trigger write stalls during a load
    @(negedge clk);
    ld_strobe = 1'b1; ld_temp = 16'h0032; tw_valid = 1'b1; tw_high = 8'h33; tw_low = 8'h11;
    #1 check(tw_ready === 1'b0, "R3", "ready low during load", {15'd0, tw_ready}, 16'd0);
    @(negedge clk);
    ld_strobe = 1'b0;
    #1 check(tw_ready === 1'b1, "R3", "ready back after load", {15'd0, tw_ready}, 16'd1);
    @(negedge clk);
    tw_valid = 1'b0;
    read_byte(4'd2, got);
    check(got === 8'h33, "R3", "stalled write upper", {8'd0, got}, 16'h0033);
    read_byte(4'd3, got);
    check(got === 8'h11, "R3", "stalled write lower", {8'd0, got}, 16'h0011);

    // R8: back-pressure on the response
    @(negedge clk);
    rdo_ready = 1'b0; rd_valid = 1'b1; rd_index = 4'd0;
    @(negedge clk);
    rd_index = 4'd4;
    check(rdo_valid === 1'b1 && rdo_data === 8'h32, "R8", "first response",
          {8'd0, rdo_data}, 16'h0032);
    check(rd_ready === 1'b0, "R8", "ready low while stalled", {15'd0, rd_ready}, 16'd0);
    @(negedge clk);
    check(rdo_data === 8'h32, "R8", "data held while stalled", {8'd0, rdo_data}, 16'h0032);
    rdo_ready = 1'b1;
    #1 check(rd_ready === 1'b1, "R8", "ready follows consumer", {15'd0, rd_ready}, 16'd1);
    @(negedge clk);
    rd_valid = 1'b0;
    check(rdo_data === 8'hFF, "R4", "byte 4 after stall", {8'd0, rdo_data}, 16'h00FF);
    @(negedge clk);
    check(rdo_valid === 1'b0, "R8", "valid drops when taken", {15'd0, rdo_valid}, 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule